// File: doc/BRIEF.md
# Interrupt CPU Interface with Split Completion

This block sits between a set of level-sensitive interrupt sources and one processor core. It picks the most urgent request that may be taken, raises a single interrupt line to the core, and lets software acknowledge and complete interrupts through a word-wide register port. It tracks which sources are active and keeps a bounded stack of the priorities being serviced, so that a more urgent interrupt can preempt one already in service.

Two completion modes are offered. In the combined mode, one end-of-interrupt write lowers the running priority and releases the source. In the split mode, the end-of-interrupt write only lowers the running priority and the source stays active. Others at the same priority can then be taken while the source waits. A separate deactivate write later releases it. This lets the handler that lowers the priority differ from the agent that finishes the work.

Per-source priorities arrive on a flat input vector, 8 bits per source. Source i has interrupt ID i.

Top module: `irq_cpu_if`

## Requirements
- R1: Control bit 0 (offset 0x000) enables signalling. While it is clear, `irq_out` is low, an acknowledge read returns 1023 and changes no state. A request left waiting is taken once the bit is set.
- R2: Control bits 5 to 8 are stored and read back unchanged, and bit 9 selects the split mode. A control read returns bits 0 and 5 to 9 as written, with all other bits zero.
- R3: A source is eligible when its level is high and it is not active. Its priority (lower is more urgent) must be strictly below the mask register (offset 0x004, 8 bits, readable) and strictly below the running priority. `irq_out` is high exactly when the block is enabled and some source is eligible.
- R4: A read of offset 0x00C returns, in bits 9:0, the ID of the eligible source with the lowest priority value. Ties go to the lowest ID, the upper bits are zero, and 1023 is returned when nothing is eligible.
- R5: An acknowledge that returns a real ID makes that source active and pushes its priority. Offset 0x014 reads the most recent pushed priority, or 0xFF when the stack is empty. An active source is not signalled again while its level stays high.
- R6: The priority stack holds STACK_DEPTH entries (default 4). While it is full, no source is eligible.
- R7: A write to offset 0x010 pops the most recent stack entry if there is one. In the combined mode (bit 9 clear), it also clears the active state of the ID in bits 9:0 of the write data.
- R8: In the split mode, a write to offset 0x010 only pops the priority and leaves the source active. Another source with the same priority then becomes eligible.
- R9: A write to offset 0x1000 in the split mode clears the active state of the ID in bits 9:0. It is ignored in the combined mode and for IDs that are not active.
- R10: After reset, control and mask read 0, the running priority reads 0xFF, no source is active and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lvl | input | NUM_SRC | Level request per source, bit i is ID i |
| prio_vec | input | NUM_SRC*8 | Priority of source i in bits 8i+7:8i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x00C acknowledges |
| reg_addr | input | 13 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| irq_out | output | 1 | Interrupt line to the core |

## Verification
Every source is raised on its own, with priorities chosen so that some fall at or above the mask. This separates masking from selection and confirms that each ID maps to its own bit. An all-sources pattern, with the lowest ID then removed, tells the priority comparison apart from the lowest-ID tie-break. A preemption chain of strictly falling priorities fills the stack and shows that a full stack blocks a more urgent request. The same chain then unwinds one pop at a time. Paired sources at one priority are completed in both modes, with deactivates to named, inactive and ignored IDs. This separates a priority drop from a deactivation, since the acknowledge read exposes which sources are still active.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;

    localparam int ADDR_W  = 13;
    localparam int PRIO_W  = 8;
    localparam int ID_W    = 10;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 13'h000;
    localparam logic [ADDR_W-1:0] OFS_MASK = 13'h004;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 13'h00C;
    localparam logic [ADDR_W-1:0] OFS_DROP = 13'h010;
    localparam logic [ADDR_W-1:0] OFS_RUN  = 13'h014;
    localparam logic [ADDR_W-1:0] OFS_DEACT = 13'h1000;

    localparam logic [ID_W-1:0]   NO_IRQ_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

    typedef struct packed {
        logic              split;
        logic [3:0]        bypass;
        logic              en;
        logic [PRIO_W-1:0] mask;
    } cif_ctrl_t;

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_cif_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]        elig,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_vec,
    output logic                      pick_valid,
    output logic [ID_W-1:0]           pick_id,
    output logic [PRIO_W-1:0]         pick_prio
);

    always_comb begin
        pick_valid = 1'b0;
        pick_id    = NO_IRQ_ID;
        pick_prio  = IDLE_PRIO;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!pick_valid || prio_vec[i*PRIO_W +: PRIO_W] < pick_prio)) begin
                pick_valid = 1'b1;
                pick_id    = ID_W'(i);
                pick_prio  = prio_vec[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
    import irq_cif_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] run_prio,
    output logic              full
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic [CW-1:0]     cnt_d, cnt_q;
    logic [PRIO_W-1:0] stk_d [DEPTH];
    logic [PRIO_W-1:0] stk_q [DEPTH];
    logic [CW-1:0]     top_idx;

    assign top_idx  = cnt_q - CW'(1);
    assign full     = (cnt_q == CW'(DEPTH));
    assign run_prio = (cnt_q == '0) ? IDLE_PRIO : stk_q[top_idx[IW-1:0]];

    always_comb begin
        cnt_d = cnt_q;
        stk_d = stk_q;
        if (pop) begin
            if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
        end else if (push && !full) begin
            stk_d[cnt_q[IW-1:0]] = push_prio;
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= IDLE_PRIO;
        end else begin
            cnt_q <= cnt_d;
            stk_q <= stk_d;
        end
    end

    assert_push_sets_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> run_prio == $past(push_prio));

    assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
    import irq_cif_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int STACK_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        irq_lvl,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_vec,
    input  logic                      reg_wr,
    input  logic                      reg_rd,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      irq_out
);

    localparam int SEL_W = $clog2(NUM_SRC);

    cif_ctrl_t          ctrl_d, ctrl_q;
    logic [NUM_SRC-1:0] active_d, active_q;
    logic [NUM_SRC-1:0] elig;
    logic               pick_valid;
    logic [ID_W-1:0]    pick_id;
    logic [PRIO_W-1:0]  pick_prio;
    logic [PRIO_W-1:0]  run_prio;
    logic               stk_full;
    logic               ack_fire;
    logic               drop_wr;
    logic               deact_wr;
    logic [ID_W-1:0]    wr_id;
    logic               unused_ok;

    assign unused_ok = ^{reg_wdata[31:10], reg_wdata[4:1]};
    assign wr_id     = reg_wdata[ID_W-1:0];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = irq_lvl[g] && !active_q[g] && !stk_full
                      && (prio_vec[g*PRIO_W +: PRIO_W] < ctrl_q.mask)
                      && (prio_vec[g*PRIO_W +: PRIO_W] < run_prio);
    end

    irq_pick #(.NUM_SRC(NUM_SRC)) pick_i (
        .elig       (elig),
        .prio_vec   (prio_vec),
        .pick_valid (pick_valid),
        .pick_id    (pick_id),
        .pick_prio  (pick_prio)
    );

    assign ack_fire = reg_rd && (reg_addr == OFS_ACK) && ctrl_q.en && pick_valid;
    assign drop_wr  = reg_wr && (reg_addr == OFS_DROP);
    assign deact_wr = reg_wr && (reg_addr == OFS_DEACT);
    assign irq_out  = ctrl_q.en && pick_valid;

    irq_prio_stack #(.DEPTH(STACK_DEPTH)) stack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_fire),
        .push_prio (pick_prio),
        .pop       (drop_wr),
        .run_prio  (run_prio),
        .full      (stk_full)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        active_d = active_q;
        if (reg_wr && reg_addr == OFS_CTRL) begin
            ctrl_d.en     = reg_wdata[0];
            ctrl_d.bypass = reg_wdata[8:5];
            ctrl_d.split  = reg_wdata[9];
        end
        if (reg_wr && reg_addr == OFS_MASK) ctrl_d.mask = reg_wdata[7:0];
        if ((drop_wr && !ctrl_q.split) || (deact_wr && ctrl_q.split)) begin
            for (int i = 0; i < NUM_SRC; i++)
                if (wr_id == ID_W'(i)) active_d[i] = 1'b0;
        end
        if (ack_fire) begin
            for (int i = 0; i < NUM_SRC; i++)
                if (pick_id == ID_W'(i)) active_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            active_q <= '0;
        end else begin
            ctrl_q   <= ctrl_d;
            active_q <= active_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_CTRL: reg_rdata = {22'd0, ctrl_q.split, ctrl_q.bypass, 4'd0, ctrl_q.en};
                OFS_MASK: reg_rdata = {24'd0, ctrl_q.mask};
                OFS_ACK:  reg_rdata = {22'd0, (ctrl_q.en && pick_valid) ? pick_id : NO_IRQ_ID};
                OFS_RUN:  reg_rdata = {24'd0, run_prio};
                default:  reg_rdata = '0;
            endcase
        end
    end

    assert_pick_not_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> !active_q[pick_id[SEL_W-1:0]]);

    assert_ack_marks_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> active_q[$past(pick_id[SEL_W-1:0])]);

    assert_ack_raises_urgency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !reg_wr) |=> run_prio < $past(run_prio));

    assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !irq_out);

    assert_split_drop_keeps_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_wr && ctrl_q.split && !reg_rd) |=> active_q == $past(active_q));

    assert_deact_ignored_combined_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_wr && !ctrl_q.split && !reg_rd) |=> active_q == $past(active_q));

endmodule

// File: tb/irq_cpu_if_tb_top.sv
module irq_cpu_if_tb_top;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lvl = '0;
    logic [N*8-1:0] prio_vec;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [12:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    irq_cpu_if dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .prio_vec(prio_vec),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [7:0] pf(int i);
        if (i % 4 == 3) return 8'hF0 + 8'(i % 16);
        return 8'h20 + 8'((i % 8) * 16);
    endfunction

    initial begin
        for (int i = 0; i < N; i++) prio_vec[i*8 +: 8] = pf(i);
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [12:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_lvl(logic [N-1:0] v);
        @(negedge clk);
        irq_lvl = v;
        #1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        #1 check("R10 irq_out", 32'(irq_out), 0);
        rd(13'h014, rv); check("R10 running prio", rv, 32'hFF);
        rd(13'h000, rv); check("R10 control", rv, 0);
        rd(13'h004, rv); check("R10 mask", rv, 0);

        // R2 control readback
        wr(13'h000, 32'hFFFF_FFFF);
        rd(13'h000, rv); check("R2 control bits", rv, 32'h3E1);
        wr(13'h000, 32'h0000_01E0);
        rd(13'h000, rv); check("R2 bypass only", rv, 32'h1E0);

        // R1 disabled: pending but not signalled or taken
        wr(13'h004, 32'hF0);
        rd(13'h004, rv); check("R3 mask readback", rv, 32'hF0);
        set_lvl(32'h1);
        check("R1 disabled irq_out", 32'(irq_out), 0);
        rd(13'h00C, rv); check("R1 disabled ack", rv, 1023);
        wr(13'h000, 32'h1);
        #1 check("R1 enabled irq_out", 32'(irq_out), 1);
        rd(13'h00C, rv); check("R1 waiting request taken", rv, 0);
        wr(13'h010, 32'h0);

        // R3 R4 R5 R7 single-source sweep, combined mode
        for (int i = 0; i < N; i++) begin
            logic ok;
            ok = (pf(i) < 8'hF0);
            set_lvl(N'(1) << i);
            check("R3 single irq_out", 32'(irq_out), 32'(ok));
            rd(13'h00C, rv); check("R4 single ack id", rv, ok ? 32'(i) : 32'd1023);
            if (ok) begin
                #1 check("R5 active not resignalled", 32'(irq_out), 0);
                rd(13'h014, rv); check("R5 running prio", rv, 32'(pf(i)));
                wr(13'h010, 32'(i));
                rd(13'h014, rv); check("R7 drop to idle", rv, 32'hFF);
                #1 check("R7 combined release", 32'(irq_out), 1);
            end
        end

        // R4 tie-break and priority ordering
        set_lvl('1);
        rd(13'h00C, rv); check("R4 all sources", rv, 0);
        rd(13'h00C, rv); check("R3 same prio not preempting", rv, 1023);
        wr(13'h010, 32'h0);
        set_lvl(~N'(1));
        rd(13'h00C, rv); check("R4 tie lowest id", rv, 8);
        wr(13'h010, 32'h8);
        wr(13'h004, 32'h20);
        rd(13'h00C, rv); check("R3 mask excludes equal", rv, 1023);
        wr(13'h004, 32'hF0);

        // R6 preemption chain fills the stack
        set_lvl(N'(1) << 6);  rd(13'h00C, rv); check("R6 chain 0x80", rv, 6);
        set_lvl(N'(1) << 5);  rd(13'h00C, rv); check("R6 chain 0x70", rv, 5);
        set_lvl(N'(1) << 4);  rd(13'h00C, rv); check("R6 chain 0x60", rv, 4);
        set_lvl(N'(1) << 2);  rd(13'h00C, rv); check("R6 chain 0x40", rv, 2);
        rd(13'h014, rv); check("R5 nested running prio", rv, 32'h40);
        set_lvl(N'(1) << 1);
        check("R6 full blocks irq_out", 32'(irq_out), 0);
        rd(13'h00C, rv); check("R6 full blocks ack", rv, 1023);
        wr(13'h010, 32'h2);
        rd(13'h014, rv); check("R7 pop one level", rv, 32'h60);
        #1 check("R6 room frees request", 32'(irq_out), 1);
        rd(13'h00C, rv); check("R6 preempt after pop", rv, 1);
        for (int k = 0; k < 4; k++) wr(13'h010, 32'h0);
        rd(13'h014, rv); check("R7 stack empty", rv, 32'hFF);
        set_lvl('0);
        for (int k = 1; k < 7; k++) wr(13'h010, 32'(k));

        // R9 deactivate ignored in combined mode
        set_lvl(N'(1));
        rd(13'h00C, rv); check("R9 prep ack", rv, 0);
        wr(13'h1000, 32'h0);
        wr(13'h000, 32'h201);
        wr(13'h010, 32'h0);
        rd(13'h00C, rv); check("R9 combined deactivate ignored", rv, 1023);
        wr(13'h1000, 32'h0);
        rd(13'h00C, rv); check("R9 split deactivate", rv, 0);
        wr(13'h010, 32'h0);
        wr(13'h1000, 32'h0);

        // R8 split mode: drop keeps active, same-prio peer eligible
        set_lvl((N'(1)) | (N'(1) << 8));
        rd(13'h00C, rv); check("R8 first", rv, 0);
        wr(13'h010, 32'h0);
        rd(13'h014, rv); check("R8 drop to idle", rv, 32'hFF);
        rd(13'h00C, rv); check("R8 peer at same prio", rv, 8);
        wr(13'h010, 32'h8);
        rd(13'h00C, rv); check("R8 both still active", rv, 1023);
        wr(13'h1000, 32'h5);
        rd(13'h00C, rv); check("R9 inactive id ignored", rv, 1023);
        wr(13'h1000, 32'h8);
        rd(13'h00C, rv); check("R9 deactivated id retaken", rv, 8);
        wr(13'h010, 32'h8);
        wr(13'h1000, 32'h0);
        rd(13'h00C, rv); check("R9 lowest id after deactivate", rv, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule